// File: doc/BRIEF.md
# Line Activity Receive Trigger

This block sits beside a single-wire packet receiver. It watches the receive line for level changes and decides when one of them marks the start of a real packet rather than noise. Every accepted level change is stamped with the value of a free-running counter and kept in a small ring of the most recent stamps. A packet is assumed to begin once a full burst of transitions fits inside a short time window. The block tests this by comparing each new stamp with the stamp written a full ring turn earlier.

When the burst test succeeds, the block pulses a receive-start output, marks the receiver busy and stops accepting further transitions. Transitions stay ignored until a re-arm pulse arrives, usually from software or from the receive path's end-of-packet signal. The same block arbitrates the shared line. A transmit request always switches transition watching off first. It is then granted only if no reception is running; otherwise it is refused with a collision pulse. A combinational output gives the time elapsed since the most recently stored transition.

Top module: `line_burst_trigger`

## Requirements
- R1: Any change of level on `line_i` between two clock edges is a transition. While watching (`mon_en_o` = 1), with neither `rearm_i` nor `tx_req_i` high in that cycle, each transition writes the current `stamp_i` into the next ring slot. Slots are used in order and the slot index wraps from EDGE_CNT-1 back to 0.
- R2: An accepted transition is compared with the stamp written EDGE_CNT-1 accepted transitions before it, which is the oldest stored stamp. If the new stamp minus that stamp is strictly less than WINDOW, `rx_start_o` is high for exactly the one cycle after the transition. A difference equal to WINDOW does not start reception.
- R3: When reception starts, `rx_busy_o` becomes 1 and `mon_en_o` becomes 0 in the same cycle that `rx_start_o` is high.
- R4: An accepted transition that fails the window test only updates the ring. Watching continues and no start is produced.
- R5: Transitions that arrive while watching is off are discarded. They are not stored, never start reception and are not replayed later. A `rearm_i` pulse without a transmit request sets `mon_en_o` to 1 and `rx_busy_o` to 0 from the next cycle.
- R6: A transmit request made while `rx_busy_o` is 1, with no re-arm in that cycle, gives a one-cycle `tx_collide_o` pulse and no grant. Reception stays busy and watching stays off.
- R7: A transmit request made with no reception running gives a one-cycle `tx_grant_o` pulse. Any transmit request switches watching off from the next cycle until a re-arm. A transition in the same cycle as a transmit request is discarded.
- R8: `since_edge_o` equals `stamp_i` minus the most recently stored stamp. It reads all ones when no stamp has been stored since reset.
- R9: All stamp differences are taken modulo 2^TS_W, so a burst that spans the counter wrapping from all ones to zero is measured correctly.
- R10: After reset the ring holds no valid stamps, so the first EDGE_CNT-1 transitions cannot start reception whatever their stamps. Outputs come up with `mon_en_o` = 1, `rx_busy_o` = 0, and all pulses at 0.
- R11: When `rearm_i` and `tx_req_i` are high in the same cycle, the re-arm is applied first. The request is therefore granted, and watching is left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Receive line level, already synchronous to clk_i |
| stamp_i | input | TS_W | Free-running timestamp counter value |
| rearm_i | input | 1 | Re-arm pulse: end reception and resume watching |
| tx_req_i | input | 1 | Transmit attempt pulse |
| rx_start_o | output | 1 | One-cycle pulse: reception begins |
| rx_busy_o | output | 1 | Reception running |
| mon_en_o | output | 1 | Transition watching enabled |
| tx_grant_o | output | 1 | One-cycle pulse: transmit request granted |
| tx_collide_o | output | 1 | One-cycle pulse: transmit request refused, reception running |
| since_edge_o | output | TS_W | Time since the most recent stored transition |

## Verification
On every cycle the assertions check the control rules that relate one cycle to the next. A start always leaves the block busy and blind. No start appears unless watching was on the cycle before. A request against a busy receiver becomes a collision. A re-arm always restores watching, and grant and collision never coincide. Whether the window test picks the right ring slot, treats a difference equal to the window as too slow, ignores empty slots after reset, and measures correctly across counter wrap can only be shown by the bench's stamp sequences. The same holds for transitions during blind periods leaving the ring and the elapsed-time output untouched.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  // Operating mode of the trigger controller.
  typedef enum logic [1:0] {
    MODE_WATCH = 2'd0,  // transitions are stamped and judged
    MODE_RECV  = 2'd1,  // a packet is being received, line is blind
    MODE_QUIET = 2'd2   // a transmit attempt took the line, blind
  } lbt_mode_e;

endpackage

// File: rtl/lbt_reset_sync.sv
module lbt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/lbt_edge_sense.sv
module lbt_edge_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o
);

  logic level_q;
  logic level_d;

  always_comb begin
    level_d = line_i;
    edge_o  = line_i ^ level_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
    end
  end

endmodule

// File: rtl/lbt_stamp_ring.sv
module lbt_stamp_ring #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TS_W  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [TS_W-1:0] stamp_i,
  output logic [TS_W-1:0] oldest_val_o,
  output logic            oldest_vld_o,
  output logic [TS_W-1:0] newest_val_o,
  output logic            newest_vld_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] wr_idx_q;
  logic [IDX_W-1:0] wr_idx_d;
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] prv_idx;

  logic [TS_W-1:0] slot_val [DEPTH];
  logic            slot_vld [DEPTH];

  always_comb begin
    nxt_idx  = (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
    prv_idx  = (wr_idx_q == '0) ? LAST_IDX : wr_idx_q - 1'b1;
    wr_idx_d = wr_en_i ? nxt_idx : wr_idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
    end
  end

  // One register slot per ring entry, each with its own write enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic            we;
    logic [TS_W-1:0] val_q;
    logic            vld_q;

    always_comb begin
      we = wr_en_i && (wr_idx_q == IDX_W'(g));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        vld_q <= 1'b0;
      end else if (we) begin
        val_q <= stamp_i;
        vld_q <= 1'b1;
      end
    end

    assign slot_val[g] = val_q;
    assign slot_vld[g] = vld_q;
  end

  // The slot about to be overwritten holds the oldest stamp.
  always_comb begin
    oldest_val_o = slot_val[nxt_idx];
    oldest_vld_o = slot_vld[nxt_idx];
    newest_val_o = slot_val[prv_idx];
    newest_vld_o = slot_vld[prv_idx];
  end

endmodule

// File: rtl/lbt_window_judge.sv
module lbt_window_judge #(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned WINDOW = 20
) (
  input  logic [TS_W-1:0] stamp_i,
  input  logic [TS_W-1:0] oldest_val_i,
  input  logic            oldest_vld_i,
  input  logic [TS_W-1:0] newest_val_i,
  input  logic            newest_vld_i,
  output logic            hit_o,
  output logic [TS_W-1:0] age_o
);

  localparam logic [TS_W-1:0] WIN_LIM = TS_W'(WINDOW);

  logic [TS_W-1:0] span;

  // Differences wrap naturally at the counter width.
  always_comb begin
    span  = stamp_i - oldest_val_i;
    hit_o = oldest_vld_i && (span < WIN_LIM);
    age_o = newest_vld_i ? (stamp_i - newest_val_i) : '1;
  end

endmodule

// File: rtl/lbt_arm_ctrl.sv
module lbt_arm_ctrl
  import lbt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic hit_i,
  input  logic rearm_i,
  input  logic tx_req_i,
  output logic accept_o,
  output logic rx_start_o,
  output logic rx_busy_o,
  output logic mon_en_o,
  output logic tx_grant_o,
  output logic tx_collide_o
);

  lbt_mode_e mode_q, mode_d;
  logic      start_q, start_d;
  logic      grant_q, grant_d;
  logic      coll_q, coll_d;
  logic      busy_eff;

  always_comb begin
    // A transmit attempt or a re-arm in this cycle masks the transition.
    accept_o = edge_i && (mode_q == MODE_WATCH) && !rearm_i && !tx_req_i;
    // Re-arm is applied before the collision check.
    busy_eff = (mode_q == MODE_RECV) && !rearm_i;
    start_d  = accept_o && hit_i;
    grant_d  = tx_req_i && !busy_eff;
    coll_d   = tx_req_i && busy_eff;

    mode_d = mode_q;
    if (tx_req_i) begin
      mode_d = busy_eff ? MODE_RECV : MODE_QUIET;
    end else if (rearm_i) begin
      mode_d = MODE_WATCH;
    end else if (start_d) begin
      mode_d = MODE_RECV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_WATCH;
      start_q <= 1'b0;
      grant_q <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
      grant_q <= grant_d;
      coll_q  <= coll_d;
    end
  end

  always_comb begin
    rx_start_o   = start_q;
    rx_busy_o    = (mode_q == MODE_RECV);
    mon_en_o     = (mode_q == MODE_WATCH);
    tx_grant_o   = grant_q;
    tx_collide_o = coll_q;
  end

endmodule

// File: rtl/line_burst_trigger.sv
module line_burst_trigger #(
  parameter int unsigned EDGE_CNT = 4,
  parameter int unsigned TS_W     = 16,
  parameter int unsigned WINDOW   = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_i,
  input  logic [TS_W-1:0] stamp_i,
  input  logic            rearm_i,
  input  logic            tx_req_i,
  output logic            rx_start_o,
  output logic            rx_busy_o,
  output logic            mon_en_o,
  output logic            tx_grant_o,
  output logic            tx_collide_o,
  output logic [TS_W-1:0] since_edge_o
);

  logic            rst_n_sync;
  logic            edge_seen;
  logic            accept;
  logic            hit;
  logic [TS_W-1:0] oldest_val;
  logic            oldest_vld;
  logic [TS_W-1:0] newest_val;
  logic            newest_vld;

  lbt_reset_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  lbt_edge_sense u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .line_i (line_i),
    .edge_o (edge_seen)
  );

  lbt_stamp_ring #(.DEPTH(EDGE_CNT), .TS_W(TS_W)) u_ring (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_sync),
    .wr_en_i      (accept),
    .stamp_i      (stamp_i),
    .oldest_val_o (oldest_val),
    .oldest_vld_o (oldest_vld),
    .newest_val_o (newest_val),
    .newest_vld_o (newest_vld)
  );

  lbt_window_judge #(.TS_W(TS_W), .WINDOW(WINDOW)) u_judge (
    .stamp_i      (stamp_i),
    .oldest_val_i (oldest_val),
    .oldest_vld_i (oldest_vld),
    .newest_val_i (newest_val),
    .newest_vld_i (newest_vld),
    .hit_o        (hit),
    .age_o        (since_edge_o)
  );

  lbt_arm_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_sync),
    .edge_i       (edge_seen),
    .hit_i        (hit),
    .rearm_i      (rearm_i),
    .tx_req_i     (tx_req_i),
    .accept_o     (accept),
    .rx_start_o   (rx_start_o),
    .rx_busy_o    (rx_busy_o),
    .mon_en_o     (mon_en_o),
    .tx_grant_o   (tx_grant_o),
    .tx_collide_o (tx_collide_o)
  );

endmodule

// File: rtl/lbt_checker.sv
module lbt_checker (
  input logic clk_i,
  input logic rst_n,
  input logic rearm_i,
  input logic tx_req_i,
  input logic rx_start_o,
  input logic rx_busy_o,
  input logic mon_en_o,
  input logic tx_grant_o,
  input logic tx_collide_o
);

  // R3
  start_blinds_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_start_o |-> (rx_busy_o && !mon_en_o));

  // R5
  no_start_when_blind_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mon_en_o |=> !rx_start_o);

  // R5
  rearm_restores_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rearm_i && !tx_req_i) |=> (mon_en_o && !rx_busy_o));

  // R6
  busy_collides_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_req_i && rx_busy_o && !rearm_i) |=> (tx_collide_o && !tx_grant_o && rx_busy_o));

  // R7
  tx_blinds_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_req_i |=> (!mon_en_o && !rx_start_o));

  // R11
  rearm_then_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_req_i && rearm_i) |=> (tx_grant_o && !rx_busy_o));

  // R7
  grant_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(tx_grant_o && tx_collide_o));

  // R3
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(mon_en_o && rx_busy_o));

endmodule

bind line_burst_trigger lbt_checker u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_sync),
  .rearm_i      (rearm_i),
  .tx_req_i     (tx_req_i),
  .rx_start_o   (rx_start_o),
  .rx_busy_o    (rx_busy_o),
  .mon_en_o     (mon_en_o),
  .tx_grant_o   (tx_grant_o),
  .tx_collide_o (tx_collide_o)
);

// File: tb/tb_line_burst_trigger.sv
module tb_line_burst_trigger;

  localparam int N   = 4;
  localparam int TW  = 16;
  localparam int WIN = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line;
  logic [TW-1:0] stamp;
  logic          rearm;
  logic          txreq;
  logic          rx_start, rx_busy, mon_en, tx_grant, tx_coll;
  logic [TW-1:0] since_edge;

  always #10 clk = ~clk;

  line_burst_trigger #(.EDGE_CNT(N), .TS_W(TW), .WINDOW(WIN)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .stamp_i      (stamp),
    .rearm_i      (rearm),
    .tx_req_i     (txreq),
    .rx_start_o   (rx_start),
    .rx_busy_o    (rx_busy),
    .mon_en_o     (mon_en),
    .tx_grant_o   (tx_grant),
    .tx_collide_o (tx_coll),
    .since_edge_o (since_edge)
  );

  typedef struct {
    logic          st;
    logic          bz;
    logic          mn;
    logic          gr;
    logic          co;
    logic [TW-1:0] age;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Reference model built from the requirements.
  logic [TW-1:0] m_slot [N];
  bit            m_vld  [N];
  int            m_wi;
  int            m_mode;  // 0 watching, 1 receiving, 2 transmit hold

  task automatic chk(input string nm, input logic [TW-1:0] act,
                     input logic [TW-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit tog, input logic [TW-1:0] st, input bit ra,
                      input bit tx, input string tag);
    exp_t          e;
    bit            acc, hit, beff;
    int            nx, pv;
    logic [TW-1:0] d;
    @(negedge clk);
    #2;
    if (tog) line = ~line;
    stamp = st;
    rearm = ra;
    txreq = tx;
    acc  = tog && (m_mode == 0) && !ra && !tx;
    nx   = (m_wi + 1) % N;
    d    = st - m_slot[nx];
    hit  = m_vld[nx] && (d < TW'(WIN));
    beff = (m_mode == 1) && !ra;
    e.gr = tx && !beff;
    e.co = tx && beff;
    e.st = acc && hit;
    if (tx) m_mode = beff ? 1 : 2;
    else if (ra) m_mode = 0;
    else if (e.st) m_mode = 1;
    if (acc) begin
      m_slot[m_wi] = st;
      m_vld[m_wi]  = 1'b1;
      m_wi         = nx;
    end
    pv    = (m_wi + N - 1) % N;
    e.age = m_vld[pv] ? st - m_slot[pv] : '1;
    e.bz  = (m_mode == 1);
    e.mn  = (m_mode == 0);
    e.tag = tag;
    @(posedge clk);
    #1;
    rearm = 1'b0;
    txreq = 1'b0;
    q.push_back(e);
  endtask

  // Monitor: compares the queued expectation away from the clock edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      chk("rx_start",   TW'(rx_start), TW'(cur.st), cur.tag);
      chk("rx_busy",    TW'(rx_busy),  TW'(cur.bz), cur.tag);
      chk("mon_en",     TW'(mon_en),   TW'(cur.mn), cur.tag);
      chk("tx_grant",   TW'(tx_grant), TW'(cur.gr), cur.tag);
      chk("tx_collide", TW'(tx_coll),  TW'(cur.co), cur.tag);
      chk("since_edge", since_edge,    cur.age,     cur.tag);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_slot[i] = '0;
      m_vld[i]  = 1'b0;
    end
    m_wi   = 0;
    m_mode = 0;
    rst_n  = 1'b0;
    line   = 1'b0;
    stamp  = '0;
    rearm  = 1'b0;
    txreq  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R10 reset state
    chk("rx_start",   TW'(rx_start), '0, "R10 reset");
    chk("rx_busy",    TW'(rx_busy),  '0, "R10 reset");
    chk("mon_en",     TW'(mon_en),   1,  "R10 reset");
    chk("tx_grant",   TW'(tx_grant), '0, "R10 reset");
    chk("since_edge", since_edge,    '1, "R10 reset");

    // R10: empty slots cannot trigger even with close stamps
    step(1, 16'd0, 0, 0, "R10 empty slot");
    step(1, 16'd1, 0, 0, "R10 empty slot");
    step(1, 16'd2, 0, 0, "R10 empty slot");
    // R4 / R1: slow transitions fill the ring and wrap the index
    step(1, 16'd400, 0, 0, "R4 slow");
    step(1, 16'd500, 0, 0, "R4 slow");
    step(1, 16'd600, 0, 0, "R1 wrap");
    step(1, 16'd700, 0, 0, "R4 slow");
    // R8 elapsed time
    step(0, 16'd730, 0, 0, "R8 age");
    // R2 boundary: difference equal to window does not start
    step(1, 16'd1000, 0, 0, "R2 prep");
    step(1, 16'd1007, 0, 0, "R2 prep");
    step(1, 16'd1014, 0, 0, "R2 prep");
    step(1, 16'd1020, 0, 0, "R2 equal window");
    step(1, 16'd1021, 0, 0, "R2 R3 burst start");
    // R5: transitions while receiving are discarded
    step(1, 16'd1030, 0, 0, "R5 ignored");
    step(1, 16'd1031, 0, 0, "R5 ignored");
    // R6 collision
    step(0, 16'd1040, 0, 1, "R6 collide");
    // R5 re-arm
    step(0, 16'd1050, 1, 0, "R5 rearm");
    step(1, 16'd1060, 0, 0, "R1 accept after rearm");
    // R7 grant and blind period
    step(0, 16'd1100, 0, 1, "R7 grant");
    step(1, 16'd1101, 0, 0, "R7 quiet");
    step(0, 16'd1110, 1, 0, "R5 rearm after tx");
    // R7 transition in the same cycle as a transmit request
    step(1, 16'd1120, 0, 1, "R7 same cycle");
    step(0, 16'd1130, 1, 0, "R5 rearm");
    // R11 re-arm and transmit together
    step(1, 16'd1200, 0, 0, "R3 second burst");
    step(1, 16'd1201, 0, 0, "R3 second burst");
    step(1, 16'd1202, 0, 0, "R3 second burst");
    step(1, 16'd1203, 0, 0, "R3 second burst");
    step(0, 16'd1210, 1, 1, "R11 rearm with tx");
    step(0, 16'd1220, 1, 0, "R5 rearm");
    // R9 burst across counter wrap
    step(1, 16'hFFF8, 0, 0, "R9 wrap");
    step(1, 16'hFFFC, 0, 0, "R9 wrap");
    step(1, 16'h0000, 0, 0, "R9 wrap");
    step(1, 16'h0004, 0, 0, "R9 wrap start");
    step(0, 16'h0010, 1, 0, "R5 final rearm");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule